// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide working form and produces the 32-bit IEEE-754 single-precision word for it. The working form is a class code, a sign, a signed unbiased exponent, a significand of parameterised width whose leading one sits at the most significant bit, and a sticky bit. The sticky bit stands for nonzero bits that were already dropped further upstream. The block sits at the end of an arithmetic pipeline, where it turns internal results into the architectural register format.

One combinational path serves both normal and subnormal results. It aligns the significand and rounds it under one of four rounding modes. It then handles a carry out of rounding and decides whether the result overflows or underflows. Everything is registered once: the packed word and the inexact, overflow and underflow flags become visible together, one clock after the inputs are presented. A trap-enable input changes only the condition under which underflow is reported.

Top module: `sp_packer`

## Requirements
- R1: While `rst_n` is low, every output is zero. Each result, with its flags, appears on the clock edge that follows the inputs.
- R2: Class code 0 (zero) packs as the sign bit followed by 31 zero bits, with no flag set.
- R3: Class code 2 (infinity) packs as the sign, exponent field 255 and fraction 0, with no flag set.
- R4: Class code 3 (NaN) packs as the sign, exponent field 255 and a fraction taken from the 23 significand bits just below the MSB, with no flag set.
- R5: For class code 1 (number), the exponent field is the unbiased exponent plus 127. The fraction is the 23 bits below the leading one. An exact result sets no flag.
- R6: Rounding mode 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward plus infinity and 3 rounds toward minus infinity. Inexact (flags bit 0) is set whenever a discarded bit or the sticky input is nonzero.
- R7: When rounding carries the significand to 2.0, the exponent rises by one and the fraction becomes zero.
- R8: When the exponent field after rounding is 255 or more, both overflow and inexact are set. The word is infinity in mode 0, in mode 2 for positive values and in mode 3 for negative values. In every other case it is the largest finite value (exponent 254, fraction all ones).
- R9: When the biased exponent is 0 or less, the significand is shifted right into the fraction field and rounded, and the exponent field is 0. Underflow is set when the result is inexact or when `uf_trap_en` is set.
- R10: When a subnormal result rounds up to 2^-126, it packs as exponent 1 and fraction 0. Inexact is set and underflow is not, whatever the trap enable.
- R11: Overflow and underflow are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_in | input | 2 | Class: 0 zero, 1 number, 2 infinity, 3 NaN |
| sign_in | input | 1 | Sign of the value |
| exp_in | input | EW | Signed unbiased exponent |
| mant_in | input | MW | Significand, leading one at MSB |
| sticky_in | input | 1 | Bits already lost below the significand |
| rmode | input | 2 | Rounding mode, encoding per R6 |
| uf_trap_en | input | 1 | Underflow trap enable |
| word_q | output | 32 | Packed single-precision word |
| inexact_q | output | 1 | Inexact flag |
| overflow_q | output | 1 | Overflow flag |
| underflow_q | output | 1 | Underflow flag |

## Verification
Rounding carry and overflow can occur on the same input. For example, an all-ones significand at biased exponent 254, rounded to nearest, carries to 2.0 and so pushes the exponent to 255. The bench applies that vector and expects infinity with overflow and inexact set. It applies the same significand at a lower exponent and expects a plain exponent increment. The subnormal path has a similar pairing: a round-up to the smallest normal with the trap enabled must give exponent 1 and must not report underflow.

// File: rtl/sp_packer.sv
module sp_packer #(
  parameter int MW = 64,
  parameter int EW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cls_in,
  input  logic                 sign_in,
  input  logic signed [EW-1:0] exp_in,
  input  logic [MW-1:0]        mant_in,
  input  logic                 sticky_in,
  input  logic [1:0]           rmode,
  input  logic                 uf_trap_en,
  output logic [31:0]          word_q,
  output logic                 inexact_q,
  output logic                 overflow_q,
  output logic                 underflow_q
);
  localparam int FB   = 23;
  localparam int BIAS = 127;
  localparam int SAW  = $clog2(MW + 1);
  localparam logic [1:0] C_ZERO = 2'd0, C_INF = 2'd2, C_NAN = 2'd3;
  localparam logic [1:0] RN = 2'd0, RZ = 2'd1, RP = 2'd2, RM = 2'd3;

  logic signed [EW+1:0] ebias, sa_full, efin;
  logic [SAW-1:0]       sa;
  logic [MW-1:0]        shifted;
  logic                 lost, g, rs, nx, up, is_sub, ovf, to_inf;
  logic [FB:0]          kept;
  logic [FB+1:0]        sum;
  logic [31:0]          word_d;
  logic                 inx_d, ovf_d, unf_d;

  assign ebias   = {{2{exp_in[EW-1]}}, exp_in} + (EW+2)'(BIAS);
  assign is_sub  = (ebias <= 0);
  assign sa_full = (EW+2)'(1) - ebias;
  assign sa      = !is_sub ? '0 : (sa_full > MW) ? SAW'(MW) : sa_full[SAW-1:0];
  assign shifted = mant_in >> sa;
  assign lost    = |(mant_in & ~({MW{1'b1}} << sa));

  assign kept = shifted[MW-1 -: FB+1];
  assign g    = shifted[MW-FB-2];
  assign rs   = (|shifted[MW-FB-3:0]) | lost | sticky_in;
  assign nx   = g | rs;

  always_comb begin
    case (rmode)
      RN:      up = g & (rs | kept[0]);
      RZ:      up = 1'b0;
      RP:      up = nx & ~sign_in;
      default: up = nx & sign_in;
    endcase
  end

  assign sum    = {1'b0, kept} + {{FB+1{1'b0}}, up};
  assign efin   = ebias + {{(EW+1){1'b0}}, sum[FB+1]};
  assign ovf    = (efin >= 255);
  assign to_inf = (rmode == RN) || (rmode == RP && !sign_in) || (rmode == RM && sign_in);

  always_comb begin
    word_d = '0;
    inx_d  = 1'b0;
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    case (cls_in)
      C_ZERO: word_d = {sign_in, 31'd0};
      C_INF:  word_d = {sign_in, 8'hFF, 23'd0};
      C_NAN:  word_d = {sign_in, 8'hFF, mant_in[MW-2 -: FB]};
      default: begin
        if (is_sub) begin
          word_d = {sign_in, 7'd0, sum[FB:0]};
          inx_d  = nx;
          unf_d  = !sum[FB] && (nx || uf_trap_en);
        end else if (ovf) begin
          ovf_d  = 1'b1;
          inx_d  = 1'b1;
          word_d = to_inf ? {sign_in, 8'hFF, 23'd0} : {sign_in, 8'hFE, {FB{1'b1}}};
        end else begin
          word_d = {sign_in, efin[7:0], sum[FB-1:0]};
          inx_d  = nx;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q      <= '0;
      inexact_q   <= 1'b0;
      overflow_q  <= 1'b0;
      underflow_q <= 1'b0;
    end else begin
      word_q      <= word_d;
      inexact_q   <= inx_d;
      overflow_q  <= ovf_d;
      underflow_q <= unf_d;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (word_q == '0 && !inexact_q && !overflow_q && !underflow_q));

  // R8
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_q |-> inexact_q);

  // R8
  ovf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_q |-> ((word_q[30:23] == 8'hFF && word_q[22:0] == '0) ||
                    (word_q[30:23] == 8'hFE && word_q[22:0] == {FB{1'b1}})));

  // R9
  unf_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_q |-> (word_q[30:23] == 8'd0));

  // R11
  no_ovf_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow_q && underflow_q));
endmodule

// File: tb/test_sp_packer.sv
module test_sp_packer;
  localparam int N = 26;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cls_in = '0, rmode = '0;
  logic sign_in = 1'b0, sticky_in = 1'b0, uf_trap_en = 1'b0;
  logic signed [15:0] exp_in = '0;
  logic [63:0] mant_in = '0;
  logic [31:0] word_q;
  logic inexact_q, overflow_q, underflow_q;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sp_packer i_sp_packer (.clk, .rst_n, .cls_in, .sign_in, .exp_in, .mant_in,
    .sticky_in, .rmode, .uf_trap_en, .word_q, .inexact_q, .overflow_q, .underflow_q);

  // flags = {overflow, underflow, inexact}; class 0 zero 1 num 2 inf 3 nan; mode 0 RN 1 RZ 2 RP 3 RM
  localparam logic [1:0]  CL [N] = '{0,2,2,3,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1};
  localparam logic        SG [N] = '{1,0,1,1,0,0,0,0,0,0,0,1,1,0,0,0,1,1,0,0,0,0,0,0,0,0};
  localparam int          EX [N] = '{0,0,0,0,0,1,0,0,0,0,0,0,0,0,127,128,200,200,200,
                                     -127,-127,-150,-127,-1000,-1000,127};
  localparam logic [63:0] MN [N] = '{64'h0, 64'h0, 64'h0, 64'hC123_4560_0000_0000,
    64'h8000_0000_0000_0000, 64'hC000_0000_0000_0000, 64'h8000_0080_0000_0000,
    64'h8000_0180_0000_0000, 64'h8000_01FF_FFFF_FFFF, 64'h8000_0000_0000_0000,
    64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
    64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'hC000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic        ST [N] = '{0,0,0,0,0,0,0,0,0,1,1,1,1,0,0,0,0,0,0,0,0,0,0,0,0,0};
  localparam logic [1:0]  RMD[N] = '{0,0,0,0,0,0,0,0,1,2,3,3,2,0,0,1,2,3,3,0,0,0,0,1,2,1};
  localparam logic        TR [N] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,1,0,1,0,0,0};
  localparam logic [31:0] EW_[N] = '{32'h8000_0000, 32'h7F80_0000, 32'hFF80_0000,
    32'hFFC1_2345, 32'h3F80_0000, 32'h4040_0000, 32'h3F80_0000, 32'h3F80_0002,
    32'h3F80_0001, 32'h3F80_0001, 32'h3F80_0000, 32'hBF80_0001, 32'hBF80_0000,
    32'h4000_0000, 32'h7F80_0000, 32'h7F7F_FFFF, 32'hFF7F_FFFF, 32'hFF80_0000,
    32'h7F7F_FFFF, 32'h0040_0000, 32'h0040_0000, 32'h0000_0001, 32'h0080_0000,
    32'h0000_0000, 32'h0000_0001, 32'h7F7F_FFFF};
  localparam logic [2:0]  EF [N] = '{0,0,0,0,0,0,1,1,1,1,1,1,1,1,5,5,5,5,5,0,2,3,1,3,3,1};
  // requirement of each vector: R2 R3 R3 R4 R5 R5 R6 x7 R7 R8 x5 R9 x3 R10 R9 x2 R8
  localparam int          RQ [N] = '{2,3,3,4,5,5,6,6,6,6,6,6,6,7,8,8,8,8,8,9,9,9,10,9,9,8};

  task automatic check(input int req, input logic [31:0] w, input logic [2:0] f);
    checks++;
    if (word_q !== w || {overflow_q, underflow_q, inexact_q} !== f) begin
      errors++;
      $display("FAIL R%0d: word %h flags %b, expected word %h flags %b",
               req, word_q, {overflow_q, underflow_q, inexact_q}, w, f);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1, 32'h0, 3'b000);  // R1 reset state
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      cls_in = CL[k]; sign_in = SG[k]; exp_in = 16'(EX[k]); mant_in = MN[k];
      sticky_in = ST[k]; rmode = RMD[k]; uf_trap_en = TR[k];
      @(posedge clk); #1;
      check(RQ[k], EW_[k], EF[k]);
    end
    // R1: nonzero inputs are held, reset forces outputs to zero
    @(negedge clk); rst_n = 1'b0;
    #1 check(1, 32'h0, 3'b000);
    @(posedge clk); #1 check(1, 32'h0, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    cls_in = 2'd1; sign_in = 1'b1; exp_in = 16'sd200; mant_in = 64'h8000_0000_0000_0000;
    rmode = 2'd0;
    @(posedge clk); #1 check(8, 32'hFF80_0000, 3'b101);  // R8 and R11 together, R1 latency
    // R10 with trap disabled too
    @(negedge clk); sign_in = 1'b0; exp_in = -16'sd127; mant_in = '1; uf_trap_en = 1'b0;
    @(posedge clk); #1 check(10, 32'h0080_0000, 3'b001);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule